// File: doc/BRIEF.md
# CRC-Protected Serial Register Slave

This block is the register front end of a multichannel converter. A host reaches a 128-entry, byte-wide register file over a mode 0 serial link (data sampled on the rising clock edge, changed on the falling edge, MSB first). Each access is a frame. The first byte holds a direction flag and a register address. The second byte holds the data. A third byte holds a CRC-8 that guards the first two bytes. The block checks the CRC on writes and adds one to every read response.

One control register is exempt from this protection. It also holds the CRC-check enable. It always uses a short two-byte frame, so the host can reach it whatever state the check is in. A burst of all-ones bytes restores every register to its default. Four staged rate registers drive an active rate word, which changes only after a set-then-clear handshake on a trigger register. A sticky flag records rejected writes and clears itself when it is read.

The serial inputs are sampled with the system clock. The serial clock must therefore run several times slower than the system clock.

Top module: `spi_crc_regslave`

## Requirements
- R1: In the first byte of a frame, bit 7 = 1 means read and bit 7 = 0 means write, and bits 6:0 give the address. A write to a normal address is a three-byte frame: command, data, check byte. The write takes effect once the third byte is complete, and several frames may follow each other within one chip-select window.
- R2: The check byte is a CRC-8 computed MSB first with polynomial 0x07 and initial value 0x00 over the command byte and then the data byte. When bit 0 of register 0x5A is 1, a write whose check byte does not match is discarded. When that bit is 0, the check byte is ignored.
- R3: On a read, the second byte returned on miso is the register value and the third byte is the CRC-8 of the read command byte followed by that value. The first byte returned is 0x00. Miso changes only after falling serial clock edges.
- R4: Address 0x5A uses a two-byte frame (command, data) with no check byte, for both reads and writes.
- R5: A write discarded for a bad check byte sets a sticky error flag. The flag is visible on crc_err_o and reads as bit 0 of address 0x59. Reading 0x59 returns the flag and then clears it.
- R6: If chip select rises before a frame is complete, the frame is dropped and no register changes.
- R7: Addresses 0x65 to 0x7F are not implemented. They read back as 0x00 and ignore writes.
- R8: Registers 0x60 to 0x63 are staged. src_active_o, which holds 0x60 in bits 31:24 down to 0x63 in bits 7:0, takes their values only when a write of bit 0 = 0 to register 0x64 follows a state in which that bit held 1.
- R9: Eight consecutive 0xFF bytes within one chip-select window restore every register to its default, clear the error flag and restore src_active_o. A byte other than 0xFF, or a chip-select rise, restarts the count.
- R10: After reset, every register is 0x00 except 0x61, which holds 0x80. src_active_o is 0x00800000, crc_err_o is 0 and miso is 0.
- R11: The byte that completes an all-ones burst also ends any frame in progress, so the next byte in the same window starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 while deselected |
| crc_err_o | output | 1 | Sticky flag for a rejected write |
| src_active_o | output | 32 | Active rate word built from the staged registers |

## Verification
The byte that completes an all-ones burst is also the second byte of a read frame. In the same clock the frame decoder wants to advance to its check-byte position and the software reset wants to restart everything. The bench provokes this case: it sets the error flag, then sends eight 0xFF bytes and, in the same chip-select window, a complete write frame. It then judges the outcome by reading back the registers, the flag and the active rate word. If the burst failed to realign the decoder, the write frame would be taken as a check byte plus a new command, and the written value would not read back.

// File: rtl/reg_spi_pkg.sv
package reg_spi_pkg;

  localparam int ADDR_W = 7;
  localparam int NREG   = 1 << ADDR_W;

  typedef enum logic [1:0] {
    FR_CMD  = 2'd0,
    FR_DATA = 2'd1,
    FR_CRC  = 2'd2
  } frame_pos_e;

  // One byte through a CRC-8 (poly 0x07), most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] din);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ din[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  // Power-on image: everything zero except the rate byte at 0x61.
  function automatic logic [NREG*8-1:0] default_image();
    logic [NREG*8-1:0] img;
    img = '0;
    img[8'h61*8 +: 8] = 8'h80;
    return img;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  input  logic         tx_load,
  input  logic [W-1:0] tx_byte,
  output logic         byte_valid,
  output logic [W-1:0] rx_byte,
  output logic         miso
);
  localparam int CW = $clog2(W);

  logic         sclk_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0] rx_q, rx_d;
  logic [W-1:0] tx_q, tx_d;
  logic [W-1:0] nxt_q, nxt_d;
  logic         pend_q, pend_d;
  logic         rise, fall;

  assign rise       = !cs_n && sclk && !sclk_q;
  assign fall       = !cs_n && !sclk && sclk_q;
  assign rx_byte    = {rx_q[W-2:0], mosi};
  assign byte_valid = rise && (cnt_q == CW'(W-1));
  assign miso       = !cs_n && tx_q[W-1];

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    nxt_d  = nxt_q;
    pend_d = pend_q;
    if (cs_n) begin
      cnt_d  = '0;
      tx_d   = '0;
      pend_d = 1'b0;
    end else begin
      if (rise) begin
        rx_d  = rx_byte;
        cnt_d = (cnt_q == CW'(W-1)) ? '0 : cnt_q + 1'b1;
      end
      if (tx_load) begin
        pend_d = 1'b1;
        nxt_d  = tx_byte;
      end
      if (fall) begin
        if (pend_q) begin
          tx_d   = nxt_q;
          pend_d = 1'b0;
        end else begin
          tx_d = {tx_q[W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      nxt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      nxt_q  <= nxt_d;
      pend_q <= pend_d;
    end
  end

  // R1: bytes are at least one sample apart
  p_byte_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R3: output held while the serial clock stays high
  p_miso_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && sclk && sclk_q) |-> $stable(miso));

endmodule

// File: rtl/crc8_pair.sv
module crc8_pair (
  input  logic [7:0] first_byte,
  input  logic [7:0] second_byte,
  output logic [7:0] crc
);
  import reg_spi_pkg::*;
  assign crc = crc8_step(crc8_step(8'h00, first_byte), second_byte);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int ADDR_W      = 7,
  parameter int IMPL_LAST   = 'h64,
  parameter int STATUS_ADDR = 'h59,
  parameter int CTRL_ADDR   = 'h5A,
  parameter int LATCH_ADDR  = 'h64,
  parameter int SRC_BASE    = 'h60,
  parameter int SRC_BYTES   = 4,
  parameter logic [(2**ADDR_W)*8-1:0] DEFAULTS = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  input  logic                   latch_go,
  output logic                   crc_en,
  output logic                   latch_bit,
  output logic [SRC_BYTES*8-1:0] active
);
  localparam int NREG = 2 ** ADDR_W;
  localparam int AW   = SRC_BYTES * 8;

  logic [7:0]    mem_q [NREG];
  logic [AW-1:0] staged, def_act;
  logic [AW-1:0] act_q, act_d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i <= IMPL_LAST && i != STATUS_ADDR) begin : g_impl
      logic [7:0] d;
      always_comb begin
        d = mem_q[i];
        if (soft_rst)
          d = DEFAULTS[i*8 +: 8];
        else if (wr_en && wr_addr == ADDR_W'(i))
          d = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[i] <= DEFAULTS[i*8 +: 8];
        else        mem_q[i] <= d;
      end
    end else begin : g_hole
      assign mem_q[i] = 8'h00;
    end
  end

  for (genvar k = 0; k < SRC_BYTES; k++) begin : g_src
    assign staged [(SRC_BYTES-1-k)*8 +: 8] = mem_q[SRC_BASE+k];
    assign def_act[(SRC_BYTES-1-k)*8 +: 8] = DEFAULTS[(SRC_BASE+k)*8 +: 8];
  end

  assign rd_data   = mem_q[rd_addr];
  assign crc_en    = mem_q[CTRL_ADDR][0];
  assign latch_bit = mem_q[LATCH_ADDR][0];
  assign active    = act_q;

  always_comb begin
    act_d = act_q;
    if (soft_rst)      act_d = def_act;
    else if (latch_go) act_d = staged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= def_act;
    else        act_q <= act_d;
  end

  // R9: burst restores the active rate word
  p_burst_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (active == def_act));

endmodule

// File: rtl/spi_crc_regslave.sv
module spi_crc_regslave #(
  parameter int ADDR_W      = reg_spi_pkg::ADDR_W,
  parameter int EXEMPT_ADDR = 'h5A,
  parameter int STATUS_ADDR = 'h59,
  parameter int LATCH_ADDR  = 'h64,
  parameter int SRC_BASE    = 'h60,
  parameter int IMPL_LAST   = 'h64,
  parameter int RST_BURST   = 8,
  parameter logic [(2**ADDR_W)*8-1:0] REG_DEFAULTS = reg_spi_pkg::default_image()
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        crc_err_o,
  output logic [31:0] src_active_o
);
  import reg_spi_pkg::*;

  localparam int FW = $clog2(RST_BURST + 1);

  logic              byte_valid;
  logic [7:0]        rx_byte;
  logic              tx_load;
  logic [7:0]        tx_byte;
  frame_pos_e        pos_q, pos_d;
  logic [7:0]        cmd_q, cmd_d, dat_q, dat_d, rd_q, rd_d;
  logic              err_q, err_d;
  logic [FW-1:0]     ff_q, ff_d;
  logic [ADDR_W-1:0] rd_addr, cur_addr;
  logic [7:0]        bank_rd, rd_value, crc_rd, crc_wr;
  logic              wr_en, latch_go, soft_rst, crc_en, latch_bit, exempt;

  spi_byte_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .byte_valid(byte_valid), .rx_byte(rx_byte), .miso(miso)
  );

  crc8_pair u_crc_rd (.first_byte(cmd_q), .second_byte(rd_q),  .crc(crc_rd));
  crc8_pair u_crc_wr (.first_byte(cmd_q), .second_byte(dat_q), .crc(crc_wr));

  reg_bank #(
    .ADDR_W(ADDR_W), .IMPL_LAST(IMPL_LAST), .STATUS_ADDR(STATUS_ADDR),
    .CTRL_ADDR(EXEMPT_ADDR), .LATCH_ADDR(LATCH_ADDR), .SRC_BASE(SRC_BASE),
    .SRC_BYTES(4), .DEFAULTS(REG_DEFAULTS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_addr(cur_addr), .wr_data(dat_d),
    .rd_addr(rd_addr), .rd_data(bank_rd),
    .latch_go(latch_go), .crc_en(crc_en), .latch_bit(latch_bit),
    .active(src_active_o)
  );

  assign cur_addr = cmd_q[ADDR_W-1:0];
  assign rd_addr  = (pos_q == FR_CMD) ? rx_byte[ADDR_W-1:0] : cur_addr;
  assign rd_value = (rd_addr == ADDR_W'(STATUS_ADDR)) ? {7'b0, err_q} : bank_rd;
  assign exempt   = (cur_addr == ADDR_W'(EXEMPT_ADDR));
  assign soft_rst = byte_valid && (rx_byte == 8'hFF) && (ff_q == FW'(RST_BURST-1));
  assign latch_go = wr_en && (cur_addr == ADDR_W'(LATCH_ADDR)) && !dat_d[0] && latch_bit;
  assign crc_err_o = err_q;

  always_comb begin
    pos_d   = pos_q;
    cmd_d   = cmd_q;
    dat_d   = dat_q;
    rd_d    = rd_q;
    err_d   = err_q;
    ff_d    = ff_q;
    wr_en   = 1'b0;
    tx_load = 1'b0;
    tx_byte = 8'h00;
    if (cs_n) begin
      pos_d = FR_CMD;
      ff_d  = '0;
    end else if (byte_valid) begin
      ff_d = (rx_byte == 8'hFF) ? ff_q + 1'b1 : '0;
      unique case (pos_q)
        FR_CMD: begin
          cmd_d = rx_byte;
          pos_d = FR_DATA;
          if (rx_byte[7]) begin
            tx_load = 1'b1;
            tx_byte = rd_value;
            rd_d    = rd_value;
            if (rd_addr == ADDR_W'(STATUS_ADDR)) err_d = 1'b0;
          end
        end
        FR_DATA: begin
          dat_d = rx_byte;
          if (exempt) begin
            pos_d = FR_CMD;
            wr_en = !cmd_q[7];
          end else begin
            pos_d = FR_CRC;
            if (cmd_q[7]) begin
              tx_load = 1'b1;
              tx_byte = crc_rd;
            end
          end
        end
        default: begin
          pos_d = FR_CMD;
          if (!cmd_q[7]) begin
            if (!crc_en || rx_byte == crc_wr) wr_en = 1'b1;
            else                               err_d = 1'b1;
          end
        end
      endcase
      if (soft_rst) begin
        pos_d   = FR_CMD;
        ff_d    = '0;
        wr_en   = 1'b0;
        tx_load = 1'b0;
        err_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= FR_CMD;
      cmd_q <= 8'h00;
      dat_q <= 8'h00;
      rd_q  <= 8'h00;
      err_q <= 1'b0;
      ff_q  <= '0;
    end else begin
      pos_q <= pos_d;
      cmd_q <= cmd_d;
      dat_q <= dat_d;
      rd_q  <= rd_d;
      err_q <= err_d;
      ff_q  <= ff_d;
    end
  end

  // R9: burst clears the sticky flag
  p_burst_clears_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !err_q);

  // R5: a rejected write never lands in the bank
  p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !$past(wr_en));

  // R6: deselect returns the decoder to a frame boundary
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (pos_q == FR_CMD));

  // R8: the active word moves only on the handshake or a burst
  p_latch_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active_o != $past(src_active_o)) |-> $past(latch_go || soft_rst));

endmodule

// File: tb/tb_spi_crc_regslave.sv
module tb_spi_crc_regslave;

  typedef struct {
    logic [7:0] d;
    logic [7:0] c;
    bit         has_crc;
    string      tag;
  } exp_t;

  typedef struct {
    logic [7:0] d;
    logic [7:0] c;
  } act_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic        crc_err_o;
  logic [31:0] src_active_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 1'b0;
  exp_t exp_q[$];
  act_t act_q[$];

  spi_crc_regslave dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .crc_err_o(crc_err_o), .src_active_o(src_active_o)
  );

  always #10 clk = ~clk;

  // Reference CRC: long division of {b0, b1, 8'h00} by x^8+x^2+x+1.
  function automatic logic [7:0] crc_ref(input logic [7:0] b0, input logic [7:0] b1);
    logic [23:0] r;
    r = {b0, b1, 8'h00};
    for (int i = 23; i >= 8; i--)
      if (r[i]) r = r ^ (24'h107 << (i - 8));
    return r[7:0];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        exp_t e;
        act_t a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        check({24'h0, a.d}, {24'h0, e.d}, {e.tag, " data"});
        if (e.has_crc) check({24'h0, a.c}, {24'h0, e.c}, {e.tag, " crc"});
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (3) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr3(input logic [6:0] a, input logic [7:0] d, input bit bad);
    logic [7:0] r;
    logic [7:0] c;
    c = crc_ref({1'b0, a}, d) ^ (bad ? 8'h01 : 8'h00);
    sel();
    xfer({1'b0, a}, r);
    xfer(d, r);
    xfer(c, r);
    desel();
  endtask

  task automatic wr2(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    sel();
    xfer({1'b0, a}, r);
    xfer(d, r);
    desel();
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] exp, input bit three, input string tag);
    logic [7:0] r0, r1, r2;
    exp_t e;
    act_t g;
    r2 = 8'h00;
    sel();
    xfer({1'b1, a}, r0);
    xfer(8'h00, r1);
    if (three) xfer(8'h00, r2);
    desel();
    check({24'h0, r0}, 32'h0, {tag, " first byte"});
    e.d = exp; e.c = crc_ref({1'b1, a}, exp); e.has_crc = three; e.tag = tag;
    g.d = r1;  g.c = r2;
    exp_q.push_back(e);
    act_q.push_back(g);
  endtask

  task automatic raw(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    check({31'h0, miso}, 32'h0, "R10 miso");
    check({31'h0, crc_err_o}, 32'h0, "R10 flag");
    check(src_active_o, 32'h0080_0000, "R10 active");
    rd(7'h61, 8'h80, 1, "R10 default 0x61");
    rd(7'h10, 8'h00, 1, "R10 default 0x10");

    // R2 check disabled: bad check byte ignored; R1/R3 write then read
    wr3(7'h10, 8'hA5, 1);
    rd(7'h10, 8'hA5, 1, "R1 R3 read after write");
    check({31'h0, crc_err_o}, 32'h0, "R2 no flag when disabled");

    // R4 short frames enable the check
    wr2(7'h5A, 8'h01);
    rd(7'h5A, 8'h01, 0, "R4 short read");

    // R2 good and bad check bytes
    wr3(7'h11, 8'h3C, 0);
    rd(7'h11, 8'h3C, 1, "R2 good crc");
    wr3(7'h11, 8'h77, 1);
    rd(7'h11, 8'h3C, 1, "R2 bad crc discarded");
    check({31'h0, crc_err_o}, 32'h1, "R5 flag set");
    rd(7'h59, 8'h01, 1, "R5 status read");
    check({31'h0, crc_err_o}, 32'h0, "R5 flag cleared");
    rd(7'h59, 8'h00, 1, "R5 status after clear");

    // R6 aborted frame
    sel();
    raw(8'h11);
    raw(8'h99);
    desel();
    rd(7'h11, 8'h3C, 1, "R6 aborted write");

    // R7 unimplemented address
    wr3(7'h70, 8'h55, 0);
    rd(7'h70, 8'h00, 1, "R7 hole reads zero");

    // R8 staged rate and handshake
    wr3(7'h60, 8'h12, 0);
    wr3(7'h61, 8'h34, 0);
    wr3(7'h62, 8'h56, 0);
    wr3(7'h63, 8'h78, 0);
    check(src_active_o, 32'h0080_0000, "R8 staged only");
    wr3(7'h64, 8'h00, 0);
    check(src_active_o, 32'h0080_0000, "R8 clear without set");
    wr3(7'h64, 8'h01, 0);
    check(src_active_o, 32'h0080_0000, "R8 set alone");
    wr3(7'h64, 8'h00, 0);
    check(src_active_o, 32'h1234_5678, "R8 latched");

    // R9 broken bursts do nothing
    sel();
    for (int i = 0; i < 7; i++) raw(8'hFF);
    raw(8'h00);
    desel();
    sel();
    for (int i = 0; i < 4; i++) raw(8'hFF);
    desel();
    sel();
    for (int i = 0; i < 4; i++) raw(8'hFF);
    desel();
    rd(7'h10, 8'hA5, 1, "R9 no reset on broken burst");
    rd(7'h5A, 8'h01, 0, "R9 check enable kept");

    // R9 + R11: burst with pending error, then a frame in the same window
    wr3(7'h12, 8'h42, 1);
    check({31'h0, crc_err_o}, 32'h1, "R5 flag before burst");
    sel();
    for (int i = 0; i < 8; i++) raw(8'hFF);
    raw(8'h13);
    raw(8'h42);
    raw(crc_ref(8'h13, 8'h42));
    desel();
    check({31'h0, crc_err_o}, 32'h0, "R9 flag cleared");
    check(src_active_o, 32'h0080_0000, "R9 active restored");
    rd(7'h10, 8'h00, 1, "R9 register restored");
    rd(7'h61, 8'h80, 1, "R9 default restored");
    rd(7'h5A, 8'h00, 0, "R9 check enable restored");
    rd(7'h13, 8'h42, 1, "R11 frame after burst");

    repeat (10) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule